// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Mode-Fault Detection

This block is a serial peripheral port that moves one byte at a time, either as the clock master or as a selected slave. Software reaches it through four byte registers on a small read/write bus: two configuration registers, a flag register and a data register. In master mode it generates the shift clock from the bus clock through a programmable divider. It shifts data most significant bit first. Outgoing bits change on the falling clock edge and incoming bits are sampled on the rising edge.

Three sticky flags report events: a byte has arrived, the transmit holding buffer is free, and a mode fault has occurred. A mode fault means that, while the port acts as master and watches its select input, another device pulled that select line low. A fault stops the running transfer at once and drops the port back to slave. Each flag is cleared by a fixed two-step bus sequence. The three flags are merged into a single interrupt line, and that line is active only while the port is enabled.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset, config register 1 (address 0) and config register 2 (address 1) read 0x00, the data register (address 3) reads 0x00, and the flag register (address 2) reads 0x02 (buffer-free flag only). The interrupt is low, ss_n_o is high and sclk_o is low.
- R2: Config register 1 keeps bit 0 = enable, bit 1 = master and bit 2 = fault-detect enable. Config register 2 keeps bit 0 = drive select as an output and bits 7:4 = divider. All other bits read 0.
- R3: In master mode, a byte accepted into the buffer is sent MSB first on mosi_o with exactly 8 rising edges of sclk_o. The bits sampled from miso_i on the rising edges form the received byte.
- R4: In master mode, one sclk_o half period lasts divider+1 bus cycles, so successive rising edges are 2*(divider+1) cycles apart.
- R5: The received flag (flag bit 0) sets when a finished byte lands in the data register. It clears only when a flag-register read that shows it set is followed directly by a data-register read. A data read with no such read before it leaves the flag set.
- R6: The buffer-free flag (flag bit 1) is set while the holding buffer is empty. A data write is accepted only if it directly follows a flag-register read that showed this flag set. Any other data write is ignored and starts no transfer.
- R7: With enable, master and fault-detect enable set and select configured as an input, a low level on ss_n_i sets the fault flag (flag bit 2). It also clears the master bit and stops the transfer, with no further sclk_o edges and no received byte.
- R8: With fault-detect enable cleared, a low ss_n_i in master mode sets no fault flag and leaves the master bit set.
- R9: The fault flag stays set until a flag-register read that shows it set is followed directly by a write to config register 1.
- R10: irq is high exactly when enable is set and at least one of the three flags is set.
- R11: In slave mode, a falling edge of ss_n_i loads the buffered byte, if there is one, into the shifter and sends it MSB first on miso_o. The byte received on mosi_i lands in the data register on the 8th rising edge of sclk_i. If no byte was buffered, the slave sends the byte it last received.
- R12: In master mode with select driven as an output, ss_n_o is low for the whole transfer and high when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq | output | 1 | Merged interrupt request |
| sclk_o | output | 1 | Shift clock driven in master mode |
| sclk_i | input | 1 | Shift clock received in slave mode |
| mosi_o | output | 1 | Master serial data out |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_i | input | 1 | Master serial data in |
| ss_n_o | output | 1 | Select driven by the master, active low |
| ss_n_i | input | 1 | Select input, active low |

## Verification
Master transfers run in loopback with bytes of all zeros, all ones, alternating bits and a lone set bit, each at a different divider. A wrong bit order, an off-by-one edge count or a divider error therefore shows up as a different received byte or a different edge spacing. The flag sequences are exercised in both orders, correct and out of order, so an out-of-order access must leave each flag untouched. In the slave runs, one transfer has a buffered byte and a second has none. This separates "send the new byte" from "send the last byte received". In the fault runs the select line is pulled low with fault detection on and then with it off.

// File: rtl/spi_mf_pkg.sv
`timescale 1ns/1ps
package spi_mf_pkg;

  typedef enum logic [1:0] {
    A_CFG1 = 2'd0,
    A_CFG2 = 2'd1,
    A_FLAG = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  localparam int C1_EN   = 0;
  localparam int C1_MST  = 1;
  localparam int C1_FDE  = 2;
  localparam int C2_SSD  = 0;
  localparam int C2_DIV0 = 4;

  localparam int FL_RXC = 0;
  localparam int FL_TXE = 1;
  localparam int FL_MF  = 2;

  function automatic logic [7:0] flag_byte(input logic rxc, input logic txe, input logic mf);
    logic [7:0] b;
    b         = 8'h00;
    b[FL_RXC] = rxc;
    b[FL_TXE] = txe;
    b[FL_MF]  = mf;
    return b;
  endfunction

  // number of bus cycles in one shift-clock half period
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/spi_mf_clkdiv.sv
`timescale 1ns/1ps
module spi_mf_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  // R4: after a tick the count restarts, so the next tick is div+1 cycles away
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/spi_mf_shifter.sv
`timescale 1ns/1ps
module spi_mf_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          half_tick,
  input  logic          abort,
  input  logic          tx_full,
  input  logic [DW-1:0] tx_byte,
  input  logic          ss_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          miso_i,
  output logic          tx_take,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte,
  output logic          busy,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          miso_o
);
  localparam int CW = $clog2(2 * DW);
  localparam logic [CW-1:0] M_LAST = CW'(2 * DW - 1);
  localparam logic [CW-1:0] S_LAST = CW'(DW - 1);

  logic [DW-1:0] shreg;
  logic          cap;
  logic [CW-1:0] edge_cnt;
  logic          ss_q, sclk_q;
  logic          ss_fall, sclk_rise, sclk_fall;
  logic          m_done, s_done;

  assign ss_fall   = ss_q && !ss_s;
  assign sclk_rise = !sclk_q && sclk_s;
  assign sclk_fall = sclk_q && !sclk_s;

  assign tx_take = en && tx_full && !abort && (master ? !busy : ss_fall);
  assign m_done  = en && master && busy && half_tick && sclk_o && (edge_cnt == M_LAST) && !abort;
  assign s_done  = en && !master && !ss_s && sclk_rise && (edge_cnt == S_LAST);
  assign rx_done = m_done || s_done;
  assign rx_byte = master ? {shreg[DW-2:0], cap} : {shreg[DW-2:0], mosi_s};

  assign mosi_o = shreg[DW-1];
  assign miso_o = shreg[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      ss_q   <= ss_s;
      sclk_q <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cap      <= 1'b0;
      edge_cnt <= '0;
      busy     <= 1'b0;
      sclk_o   <= 1'b0;
    end else if (!en || abort) begin
      busy     <= 1'b0;
      sclk_o   <= 1'b0;
      edge_cnt <= '0;
    end else if (master) begin
      if (tx_take) begin
        shreg    <= tx_byte;
        busy     <= 1'b1;
        sclk_o   <= 1'b0;
        edge_cnt <= '0;
      end else if (busy && half_tick) begin
        edge_cnt <= edge_cnt + CW'(1);
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          cap    <= miso_i;
        end else begin
          sclk_o <= 1'b0;
          shreg  <= {shreg[DW-2:0], cap};
          if (edge_cnt == M_LAST) busy <= 1'b0;
        end
      end
    end else begin
      busy   <= 1'b0;
      sclk_o <= 1'b0;
      if (ss_s) begin
        edge_cnt <= '0;
      end else if (tx_take) begin
        shreg <= tx_byte;
      end else if (sclk_rise) begin
        cap      <= mosi_s;
        edge_cnt <= (edge_cnt == S_LAST) ? '0 : edge_cnt + CW'(1);
      end else if (sclk_fall) begin
        shreg <= {shreg[DW-2:0], cap};
      end
    end
  end

  // R7: an abort ends the transfer and parks the clock low
  a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !sclk_o));

  // R4: while a master transfer runs, the shift clock moves only on a divider tick
  a_r4_clock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && busy && !half_tick && !abort) |=> $stable(sclk_o));

  // R3: a finished master transfer leaves the engine idle
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !busy);
endmodule

// File: rtl/spi_mf_regs.sv
`timescale 1ns/1ps
module spi_mf_regs
  import spi_mf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  input  logic             fault,
  input  logic             tx_take,
  input  logic             rx_done,
  input  logic [DW-1:0]    rx_byte,
  output logic [DW-1:0]    rdata,
  output logic             en,
  output logic             master,
  output logic             fault_en,
  output logic             ss_drive,
  output logic [DIV_W-1:0] div,
  output logic             tx_full,
  output logic [DW-1:0]    tx_buf,
  output logic             irq
);
  logic [DW-1:0] rx_data;
  logic          rxc, mf, txe;
  logic          rxc_arm, txe_arm, mf_arm;
  logic          wr_c1, wr_c2, wr_dat, rd_flag, rd_dat;

  assign txe     = !tx_full;
  assign wr_c1   = wr_en && (addr == A_CFG1);
  assign wr_c2   = wr_en && (addr == A_CFG2);
  assign wr_dat  = wr_en && (addr == A_DATA);
  assign rd_flag = rd_en && (addr == A_FLAG);
  assign rd_dat  = rd_en && (addr == A_DATA);
  assign irq     = en && (rxc || txe || mf);

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CFG1: begin
        rdata[C1_EN]  = en;
        rdata[C1_MST] = master;
        rdata[C1_FDE] = fault_en;
      end
      A_CFG2: begin
        rdata[C2_SSD]          = ss_drive;
        rdata[C2_DIV0 +: DIV_W] = div;
      end
      A_FLAG:  rdata = DW'(flag_byte(rxc, txe, mf));
      default: rdata = rx_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; master <= 1'b0; fault_en <= 1'b0;
      ss_drive <= 1'b0; div <= '0;
      tx_buf <= '0; tx_full <= 1'b0;
      rx_data <= '0; rxc <= 1'b0; mf <= 1'b0;
      rxc_arm <= 1'b0; txe_arm <= 1'b0; mf_arm <= 1'b0;
    end else begin
      if (wr_c1) begin
        en       <= wdata[C1_EN];
        master   <= wdata[C1_MST];
        fault_en <= wdata[C1_FDE];
      end
      if (fault) master <= 1'b0;
      if (wr_c2) begin
        ss_drive <= wdata[C2_SSD];
        div      <= wdata[C2_DIV0 +: DIV_W];
      end
      if (tx_take) tx_full <= 1'b0;
      else if (wr_dat && txe_arm) begin
        tx_buf  <= wdata;
        tx_full <= 1'b1;
      end
      if (rx_done) begin
        rx_data <= rx_byte;
        rxc     <= 1'b1;
      end else if (rd_dat && rxc_arm) begin
        rxc <= 1'b0;
      end
      if (fault) mf <= 1'b1;
      else if (wr_c1 && mf_arm) mf <= 1'b0;
      if (rd_flag) begin
        rxc_arm <= rxc;
        txe_arm <= txe;
        mf_arm  <= mf;
      end else if (wr_en || rd_en) begin
        rxc_arm <= 1'b0;
        txe_arm <= 1'b0;
        mf_arm  <= 1'b0;
      end
    end
  end

  // R6: a data write without the arming read leaves the buffer alone
  a_r6_unarmed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !txe_arm) |=> $stable(tx_buf));

  // R5: the armed data read clears the received flag
  a_r5_rxc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && rxc_arm && !rx_done) |=> !rxc);

  // R7: a fault leaves the flag set and the port demoted
  a_r7_demote: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (mf && !master));

  // R9: the fault flag holds until the armed config write
  a_r9_mf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mf && !(wr_c1 && mf_arm)) |=> mf);
endmodule

// File: rtl/spi_mf_ctrl.sv
`timescale 1ns/1ps
module spi_mf_ctrl #(
  parameter int DW    = 8,
  parameter int DIV_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          sclk_o,
  input  logic          sclk_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          ss_n_o,
  input  logic          ss_n_i
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_INIT = 3'b100;  // {ss, sclk, mosi}

  logic [NSYNC-1:0] sy1, sy2, sy_in;
  logic             ss_s, sclk_s, mosi_s;
  logic             en, master, fault_en, ss_drive, tx_full, fault;
  logic             tx_take, rx_done, busy, half_tick;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    tx_buf, rx_byte;

  assign sy_in = {ss_n_i, sclk_i, mosi_i};

  generate
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sy1[g] <= SYNC_INIT[g];
          sy2[g] <= SYNC_INIT[g];
        end else begin
          sy1[g] <= sy_in[g];
          sy2[g] <= sy1[g];
        end
      end
    end
  endgenerate

  assign ss_s   = sy2[2];
  assign sclk_s = sy2[1];
  assign mosi_s = sy2[0];

  assign fault  = en && master && fault_en && !ss_drive && !ss_s;
  assign ss_n_o = !(master && ss_drive && busy);

  spi_mf_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .fault(fault), .tx_take(tx_take), .rx_done(rx_done),
    .rx_byte(rx_byte), .rdata(rdata), .en(en), .master(master),
    .fault_en(fault_en), .ss_drive(ss_drive), .div(div), .tx_full(tx_full),
    .tx_buf(tx_buf), .irq(irq)
  );

  spi_mf_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en && master && busy), .div(div), .tick(half_tick)
  );

  spi_mf_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .half_tick(half_tick),
    .abort(fault), .tx_full(tx_full), .tx_byte(tx_buf), .ss_s(ss_s),
    .sclk_s(sclk_s), .mosi_s(mosi_s), .miso_i(miso_i), .tx_take(tx_take),
    .rx_done(rx_done), .rx_byte(rx_byte), .busy(busy), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_o(miso_o)
  );

  // R12: with select driven, a running master transfer always holds select low
  a_r12_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && master && ss_drive) |-> !ss_n_o);
endmodule

// File: tb/tb_spi_mf_ctrl.sv
`timescale 1ns/1ps
module tb_spi_mf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sclk_o, mosi_o, miso_o, ss_n_o;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0, nrise = 0, t_last = 0, t_prev = 0;
  logic sclk_prev = 1'b0;

  always #4 clk = ~clk;

  spi_mf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk_o(sclk_o), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(mosi_o),
    .ss_n_o(ss_n_o), .ss_n_i(ss_n_i)
  );

  // rising-edge monitor on the generated shift clock
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclk_o && !sclk_prev) begin
      t_prev = t_last;
      t_last = cyc;
      nrise  = nrise + 1;
    end
    sclk_prev = sclk_o;
  end

  // {divider, byte}
  localparam logic [11:0] VEC [0:4] = '{12'h0A5, 12'h100, 12'h3FF, 12'h25A, 12'h701};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_rxc(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd2, st);
      if (st[0]) break;
    end
  endtask

  task automatic slave_xfer(input logic [7:0] mb, output logic [7:0] seen);
    seen = 8'h00;
    @(negedge clk); ss_n_i = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = mb[i];
      repeat (8) @(negedge clk);
      seen[i] = miso_o;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d, st, seen;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 cfg1", d, 8'h00);
    rd(2'd1, d); chk("R1 cfg2", d, 8'h00);
    rd(2'd2, d); chk("R1 flags", d, 8'h02);
    rd(2'd3, d); chk("R1 data", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 ss_n_o", ss_n_o, 1);
    chk("R1 sclk_o", sclk_o, 0);

    // R2 register fields
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 cfg2 fields", d, 8'hF1);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 cfg1 fields", d, 8'h07);

    // R3 R4 R12 master loopback vectors
    foreach (VEC[k]) begin
      logic [3:0] dv;
      logic [7:0] by;
      dv = VEC[k][11:8];
      by = VEC[k][7:0];
      wr(2'd1, {dv, 4'b0001});
      wr(2'd0, 8'h03);
      base = nrise;
      rd(2'd2, st);
      wr(2'd3, by);
      @(negedge clk);
      chk("R12 ss low in transfer", ss_n_o, 0);
      wait_rxc(st);
      chk("R5 rxc set", st[0], 1);
      rd(2'd3, d);   chk("R3 loopback byte", d, by);
      chk("R3 eight rising edges", nrise - base, 8);
      chk("R4 edge spacing", t_last - t_prev, 2 * (dv + 1));
      chk("R12 ss high idle", ss_n_o, 1);
      rd(2'd2, st);  chk("R5 rxc cleared", st, 8'h02);
    end

    // R5 unarmed data read keeps the flag
    wr(2'd1, 8'h01); wr(2'd0, 8'h03);
    rd(2'd2, st); wr(2'd3, 8'h77);
    repeat (60) @(negedge clk);
    rd(2'd3, d);  chk("R5 data value", d, 8'h77);
    rd(2'd2, st); chk("R5 unarmed read keeps rxc", st, 8'h03);
    chk("R10 irq with flags", irq, 1);
    rd(2'd3, d);
    rd(2'd2, st); chk("R5 armed read clears rxc", st, 8'h02);

    // R6 write without arming is ignored
    rd(2'd2, st); rd(2'd0, d);
    base = nrise;
    wr(2'd3, 8'h99);
    repeat (60) @(negedge clk);
    chk("R6 ignored write, no edges", nrise - base, 0);
    rd(2'd2, st); chk("R6 buffer still free", st, 8'h02);

    // R8 no fault with detection disabled
    wr(2'd1, 8'h30); wr(2'd0, 8'h03);
    ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    rd(2'd2, st); chk("R8 no fault flag", st[2], 0);
    rd(2'd0, d);  chk("R8 master kept", d, 8'h03);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R7 fault during a transfer
    wr(2'd0, 8'h07);
    rd(2'd2, st); wr(2'd3, 8'hFF);
    repeat (20) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    base = nrise;
    rd(2'd2, st); chk("R7 fault flag, no rxc", st, 8'h06);
    rd(2'd0, d);  chk("R7 master cleared", d, 8'h05);
    chk("R10 irq on fault", irq, 1);
    repeat (60) @(negedge clk);
    chk("R7 clock stopped", nrise - base, 0);
    chk("R7 sclk parked low", sclk_o, 0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R9 clear sequence
    wr(2'd0, 8'h05);
    rd(2'd2, st); chk("R9 unarmed write keeps fault", st[2], 1);
    wr(2'd0, 8'h05);
    rd(2'd2, st); chk("R9 armed write clears fault", st, 8'h02);
    chk("R10 irq from free buffer", irq, 1);
    wr(2'd0, 8'h00);
    chk("R10 irq gated by enable", irq, 0);

    // R11 slave transfers
    wr(2'd1, 8'h00); wr(2'd0, 8'h01);
    rd(2'd2, st); wr(2'd3, 8'hA5);
    slave_xfer(8'h3C, seen);
    chk("R11 slave sends buffered byte", seen, 8'hA5);
    rd(2'd2, st); chk("R11 slave rxc", st, 8'h03);
    rd(2'd3, d);  chk("R11 slave received", d, 8'h3C);
    slave_xfer(8'h81, seen);
    chk("R11 slave resends last received", seen, 8'h3C);
    rd(2'd2, st);
    rd(2'd3, d);  chk("R11 second received", d, 8'h81);

    finish_run();
  end
endmodule